// File: doc/BRIEF.md
# Timer output toggle flip-flop

This block holds the single bit that drives a timer output pin. The bit flips on a hardware event that the timer mode selects: a counter compare match or a counter wrap. Hardware flips happen only while the inversion enable is set. Software can also clear, set or flip the bit at any time by presenting a 2-bit command together with a one-cycle strobe.

When a hardware flip and a software command land in the same clock cycle, a fixed priority decides the result. A software clear or set wins outright. A software flip and a hardware flip together produce a single inversion. The no-operation code leaves the hardware flip to act alone.

The inversion enable, the mode and the 8-bit source select are copied into internal configuration registers only while the timer is stopped. Changes made to these inputs while the timer runs have no effect until the timer stops again. The counters and the pin multiplexing sit outside the block.

Top module: `tmr_out_toggle`

## Requirements
- R1: While `rst` is 1 at a rising edge, `tgl_out` is 0 after that edge.
- R2: With `sw_cmd_vld` = 1 and no enabled hardware event, the command takes effect at that edge: code 2'b01 makes `tgl_out` 0, code 2'b10 makes it 1, and code 2'b00 inverts it. Software commands act whatever the state of the inversion enable.
- R3: When the latched inversion enable is 0, no counter event changes `tgl_out`.
- R4: In mode 2'b00 (8-bit interval), latched `cfg_src_sel` = 0 makes `cnt0_hit_a` the only flip source, and `cfg_src_sel` = 1 makes `cnt1_hit` the only one.
- R5: In mode 2'b01 (16-bit interval), `cnt1_hit` is the only flip source.
- R6: In mode 2'b10 (PWM), `cnt0_hit_a` and `cnt_wrap` are the flip sources, and `cnt1_hit` is ignored.
- R7: In mode 2'b11 (PPG), `cnt0_hit_a` and `cnt0_hit_b` are the flip sources, and `cnt1_hit` and `cnt_wrap` are ignored.
- R8: Two enabled sources asserted in the same cycle cause a single inversion.
- R9: A hardware flip and a software code 2'b00 in the same cycle invert `tgl_out` exactly once.
- R10: A hardware flip in the same cycle as software code 2'b10 leaves `tgl_out` at 1, and with code 2'b01 leaves it at 0.
- R11: Code 2'b11 is a software no-op, and a hardware flip in that cycle is applied as usual.
- R12: `cfg_inv_en`, `cfg_mode` and `cfg_src_sel` are captured at an edge only when `run` is 0. Values presented while `run` is 1 are ignored until an edge with `run` at 0, and they govern events from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Timer running; configuration is frozen while 1 |
| cfg_inv_en | input | 1 | Hardware inversion enable |
| cfg_mode | input | 2 | Timer mode: 00 8-bit interval, 01 16-bit interval, 10 PWM, 11 PPG |
| cfg_src_sel | input | 1 | 8-bit mode source: 0 counter 0, 1 counter 1 |
| cnt0_hit_a | input | 1 | Counter 0 matched its first compare value (pulse) |
| cnt0_hit_b | input | 1 | Counter 0 matched its second compare value (pulse) |
| cnt1_hit | input | 1 | Counter 1 matched its compare value (pulse) |
| cnt_wrap | input | 1 | Counter 2^n wrap in PWM mode (pulse) |
| sw_cmd_vld | input | 1 | Software command strobe |
| sw_cmd | input | 2 | Software command: 00 invert, 01 clear, 10 set, 11 no-op |
| tgl_out | output | 1 | Registered flip-flop value |

## Verification
Assertions check the following on every cycle: the collision outcomes for set, clear and invert, the single flip for a lone hardware event, the bit holding when nothing acts on it, the frozen configuration while running, and the mode-specific rejection of sources that do not belong to the mode. Only the bench's scenarios show end-to-end sequences. These include a configuration change made while running staying dormant until a stop, the selected 8-bit source switching after that stop, and the full walk through every mode with its ignored inputs, all compared against an independent reference model.

// File: rtl/tgl_pkg.sv
package tgl_pkg;

  localparam int MODE_W = 2;
  localparam int CMD_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_IV8  = 2'b00,
    MODE_IV16 = 2'b01,
    MODE_PWM  = 2'b10,
    MODE_PPG  = 2'b11
  } tmode_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_FLIP = 2'b00,
    CMD_CLR  = 2'b01,
    CMD_SET  = 2'b10,
    CMD_NOP  = 2'b11
  } swcmd_e;

  typedef struct packed {
    logic   inv_en;
    tmode_e mode;
    logic   src_sel;
  } cfg_t;

  localparam cfg_t CFG_RST = '{inv_en: 1'b0, mode: MODE_IV8, src_sel: 1'b0};

endpackage

// File: rtl/tgl_cfg_latch.sv
module tgl_cfg_latch
  import tgl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  cfg_t cfg_in,
  output cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= CFG_RST;
    else if (!run) cfg_q <= cfg_in;
  end

  // R12: configuration frozen while the timer runs
  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(cfg_q));

  // R12: configuration tracks inputs while stopped
  p_cfg_load_r12: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cfg_q == $past(cfg_in)));

endmodule

// File: rtl/tgl_evt_sel.sv
module tgl_evt_sel
  import tgl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg,
  input  logic hit_a,
  input  logic hit_b,
  input  logic hit1,
  input  logic wrap,
  output logic evt
);

  always_comb begin
    unique case (cfg.mode)
      MODE_IV8:  evt = cfg.src_sel ? hit1 : hit_a;
      MODE_IV16: evt = hit1;
      MODE_PWM:  evt = hit_a | wrap;
      MODE_PPG:  evt = hit_a | hit_b;
      default:   evt = 1'b0;
    endcase
  end

  // R5: in 16-bit mode only counter 1 matters
  p_iv16_src_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_IV16 && !hit1) |-> !evt);

  // R6: PWM ignores counter 1
  p_pwm_src_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_PWM && !hit_a && !wrap) |-> !evt);

  // R7: PPG ignores counter 1 and wrap
  p_ppg_src_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_PPG && !hit_a && !hit_b) |-> !evt);

  // R8: any selected source yields an event
  p_ppg_any_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_PPG && hit_a && hit_b) |-> evt);

endmodule

// File: rtl/tgl_core.sv
module tgl_core
  import tgl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   hw_tgl,
  input  logic   cmd_vld,
  input  swcmd_e cmd,
  output logic   q
);

  logic q_nxt;
  logic sw_active;

  assign sw_active = cmd_vld && (cmd != CMD_NOP);

  always_comb begin
    q_nxt = hw_tgl ? ~q : q;
    if (sw_active) begin
      unique case (cmd)
        CMD_FLIP: q_nxt = ~q;
        CMD_CLR:  q_nxt = 1'b0;
        CMD_SET:  q_nxt = 1'b1;
        default:  q_nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end

  // R1: reset clears the output
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !q);

  // R10: set wins over hardware flip
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd == CMD_SET) |=> q);

  // R10: clear wins over hardware flip
  p_clr_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd == CMD_CLR) |=> !q);

  // R9: software flip inverts exactly once
  p_one_flip_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd == CMD_FLIP) |=> (q != $past(q)));

  // R11: hardware flip alone or with no-op inverts
  p_hw_flip_r11: assert property (@(posedge clk) disable iff (rst)
    (hw_tgl && (!cmd_vld || cmd == CMD_NOP)) |=> (q != $past(q)));

  // R3: nothing acting leaves the bit alone
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!hw_tgl && (!cmd_vld || cmd == CMD_NOP)) |=> $stable(q));

endmodule

// File: rtl/tmr_out_toggle.sv
module tmr_out_toggle
  import tgl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cfg_inv_en,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_src_sel,
  input  logic              cnt0_hit_a,
  input  logic              cnt0_hit_b,
  input  logic              cnt1_hit,
  input  logic              cnt_wrap,
  input  logic              sw_cmd_vld,
  input  logic [CMD_W-1:0]  sw_cmd,
  output logic              tgl_out
);

  cfg_t cfg_in;
  cfg_t cfg_q;
  logic evt;
  logic hw_tgl;

  assign cfg_in = '{inv_en: cfg_inv_en, mode: tmode_e'(cfg_mode), src_sel: cfg_src_sel};

  tgl_cfg_latch u_cfg (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  tgl_evt_sel u_sel (
    .clk   (clk),
    .rst   (rst),
    .cfg   (cfg_q),
    .hit_a (cnt0_hit_a),
    .hit_b (cnt0_hit_b),
    .hit1  (cnt1_hit),
    .wrap  (cnt_wrap),
    .evt   (evt)
  );

  assign hw_tgl = cfg_q.inv_en & evt;

  tgl_core u_core (
    .clk     (clk),
    .rst     (rst),
    .hw_tgl  (hw_tgl),
    .cmd_vld (sw_cmd_vld),
    .cmd     (swcmd_e'(sw_cmd)),
    .q       (tgl_out)
  );

  // R3: disabled inversion blocks hardware flips
  p_inv_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.inv_en && !sw_cmd_vld) |=> $stable(tgl_out));

endmodule

// File: tb/tmr_out_toggle_test.sv
module tmr_out_toggle_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, run, cfg_inv_en, cfg_src_sel;
  logic [1:0] cfg_mode, sw_cmd;
  logic cnt0_hit_a, cnt0_hit_b, cnt1_hit, cnt_wrap, sw_cmd_vld;
  logic tgl_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit    q_exp[$];
  string q_tag[$];

  bit m_ff = 0;
  bit m_inv = 0;
  bit [1:0] m_mode = 0;
  bit m_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_out_toggle uut (
    .clk(clk), .rst(rst), .run(run), .cfg_inv_en(cfg_inv_en),
    .cfg_mode(cfg_mode), .cfg_src_sel(cfg_src_sel),
    .cnt0_hit_a(cnt0_hit_a), .cnt0_hit_b(cnt0_hit_b), .cnt1_hit(cnt1_hit),
    .cnt_wrap(cnt_wrap), .sw_cmd_vld(sw_cmd_vld), .sw_cmd(sw_cmd),
    .tgl_out(tgl_out)
  );

  function automatic bit ref_next(bit cur, bit a, bit b, bit h1, bit w, bit cv, bit [1:0] c);
    bit ev;
    bit hw;
    case (m_mode)
      2'b00:   ev = m_sel ? h1 : a;
      2'b01:   ev = h1;
      2'b10:   ev = a | w;
      default: ev = a | b;
    endcase
    hw = m_inv & ev;
    if (cv && c == 2'b00) return ~cur;
    if (cv && c == 2'b01) return 1'b0;
    if (cv && c == 2'b10) return 1'b1;
    return hw ? ~cur : cur;
  endfunction

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1; run = 0; cfg_inv_en = 0; cfg_mode = 0; cfg_src_sel = 0;
    cnt0_hit_a = 0; cnt0_hit_b = 0; cnt1_hit = 0; cnt_wrap = 0;
    sw_cmd_vld = 0; sw_cmd = 2'b11;
    m_ff = 0; m_inv = 0; m_mode = 0; m_sel = 0;
    q_exp.push_back(1'b0); q_tag.push_back(tag);
    @(negedge clk);
    q_exp.push_back(1'b0); q_tag.push_back(tag);
    rst = 0;
  endtask

  task automatic step(bit r, bit inv, bit [1:0] md, bit sel,
                      bit a, bit b, bit h1, bit w, bit cv, bit [1:0] c, string tag);
    @(negedge clk);
    run = r; cfg_inv_en = inv; cfg_mode = md; cfg_src_sel = sel;
    cnt0_hit_a = a; cnt0_hit_b = b; cnt1_hit = h1; cnt_wrap = w;
    sw_cmd_vld = cv; sw_cmd = c;
    m_ff = ref_next(m_ff, a, b, h1, w, cv, c);
    if (!r) begin
      m_inv = inv; m_mode = md; m_sel = sel;
    end
    q_exp.push_back(m_ff); q_tag.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        bit e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (tgl_out !== e) begin
          fails++;
          $display("FAIL %s: tgl_out=%0b expected=%0b", t, tgl_out, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    do_reset("R1");
    // 8-bit mode, counter 0 source
    step(0,1,2'b00,0, 0,0,0,0, 0,2'b11, "R12");
    step(1,1,2'b00,0, 1,0,0,0, 0,2'b11, "R4");
    step(1,1,2'b00,0, 0,0,1,0, 0,2'b11, "R4");
    step(1,1,2'b00,0, 0,1,0,1, 0,2'b11, "R4");
    // source change while running stays dormant
    step(1,1,2'b00,1, 0,0,1,0, 0,2'b11, "R12");
    step(1,1,2'b00,1, 1,0,0,0, 0,2'b11, "R12");
    step(0,1,2'b00,1, 0,0,0,0, 0,2'b11, "R12");
    step(1,1,2'b00,1, 0,0,1,0, 0,2'b11, "R4");
    step(1,1,2'b00,1, 1,0,0,0, 0,2'b11, "R4");
    // software commands alone
    step(1,1,2'b00,1, 0,0,0,0, 1,2'b01, "R2");
    step(1,1,2'b00,1, 0,0,0,0, 1,2'b10, "R2");
    step(1,1,2'b00,1, 0,0,0,0, 1,2'b00, "R2");
    step(1,1,2'b00,1, 0,0,0,0, 1,2'b11, "R11");
    // collisions
    step(1,1,2'b00,1, 0,0,1,0, 1,2'b10, "R10");
    step(1,1,2'b00,1, 0,0,1,0, 1,2'b01, "R10");
    step(1,1,2'b00,1, 0,0,1,0, 1,2'b11, "R11");
    step(1,1,2'b00,1, 0,0,1,0, 1,2'b00, "R9");
    step(1,1,2'b00,1, 0,0,1,0, 1,2'b00, "R9");
    // inversion disabled
    step(0,0,2'b00,1, 0,0,0,0, 0,2'b11, "R12");
    step(1,0,2'b00,1, 0,0,1,0, 0,2'b11, "R3");
    step(1,1,2'b00,1, 0,0,1,0, 0,2'b11, "R12");
    step(1,1,2'b00,1, 0,0,0,0, 1,2'b00, "R2");
    step(1,0,2'b00,1, 1,1,1,1, 0,2'b11, "R3");
    // 16-bit mode
    step(0,1,2'b01,0, 0,0,0,0, 0,2'b11, "R12");
    step(1,1,2'b01,0, 0,0,1,0, 0,2'b11, "R5");
    step(1,1,2'b01,0, 1,1,0,0, 0,2'b11, "R5");
    step(1,1,2'b01,0, 0,0,0,1, 0,2'b11, "R5");
    // PWM mode
    step(0,1,2'b10,0, 0,0,0,0, 0,2'b11, "R12");
    step(1,1,2'b10,0, 1,0,0,0, 0,2'b11, "R6");
    step(1,1,2'b10,0, 0,0,0,1, 0,2'b11, "R6");
    step(1,1,2'b10,0, 0,1,1,0, 0,2'b11, "R6");
    step(1,1,2'b10,0, 1,0,0,1, 0,2'b11, "R8");
    // PPG mode
    step(0,1,2'b11,0, 0,0,0,0, 0,2'b11, "R12");
    step(1,1,2'b11,0, 1,0,0,0, 0,2'b11, "R7");
    step(1,1,2'b11,0, 0,1,0,0, 0,2'b11, "R7");
    step(1,1,2'b11,0, 0,0,1,1, 0,2'b11, "R7");
    step(1,1,2'b11,0, 1,1,0,0, 0,2'b11, "R8");
    step(1,1,2'b11,0, 1,1,0,0, 1,2'b10, "R10");
    // reset from a set state
    do_reset("R1");
    step(1,0,2'b00,0, 1,1,1,1, 0,2'b11, "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule